// File: doc/BRIEF.md
# Serial Display Link Pixel Packer and 7:1 Serializer

This block accepts one parallel pixel (eight bits each of red, green and blue, plus horizontal sync, vertical sync and data-enable) and spreads its bits across four differential-style data lanes as 7-bit words. Each lane word is then shifted out serially, one bit per fast clock, alongside a clock lane that repeats a fixed 7-bit pattern. The whole block runs on the fast clock (seven times the link word rate). A one-cycle `pix_take` strobe tells the upstream source on which rising edge a pixel is sampled.

Three run-time controls select the format. `cfg_deep` picks six or eight significant bits per primary. `cfg_jeida` picks one of two bit-placement conventions for the eight-bit case. `cfg_dual` selects one link or two. In dual mode the block takes two pixels per word period and sends the first one on the odd link and the second on the even link, so each link runs at half the incoming pixel rate. In single mode the even link is held low. Output buffers, PLLs and signal levels are outside the block; every serial output is a plain logic bit.

Top module: `lvds_tx_packer`

## Requirements
- R1: An internal phase counter cycles through 0..6, one step per clock. `pix_take` is high in phase 6, and in dual mode also in phase 3. It is never high on two consecutive cycles. The pixel on the inputs is sampled on the rising edge that ends a cycle with `pix_take` high.
- R2: Words load into the shift registers on the edge that ends phase 6. In the next seven cycles each serial output shows word slot 6 first, then slots 5 down to 0.
- R3: Each primary is reduced to a 6-bit core. Lane 0 = {G core bit 0, R core[5:0]}. Lane 1 = {B core[1:0], G core[5:1]}. Lane 2 = {DE, VSYNC, HSYNC, B core[5:2]}. Each of these is written as slot 6 down to slot 0.
- R4: Lane 2 slots 6, 5 and 4 carry DE, VSYNC and HSYNC in every mapping and depth.
- R5: With eight bits and `cfg_jeida`=0, the core is bits [5:0] of each primary. Lane 3 = {R[7:6], G[7:6], B[7:6], 0}.
- R6: With eight bits and `cfg_jeida`=1, the core is bits [7:2] of each primary. Lane 3 = {R[1:0], G[1:0], B[1:0], 0}.
- R7: With six bits (`cfg_deep`=0), the core is bits [7:2] of each primary whatever `cfg_jeida` is set to. Lane 3 is all zero.
- R8: The clock lane of each active link repeats 1100011, slot 6 first, once per word.
- R9: In single mode the odd link carries the pixel taken in phase 6. All even-link lanes, including its clock lane, stay low.
- R10: In dual mode the pixel taken in phase 3 goes to the odd link and the pixel taken in phase 6 goes to the even link. Both links load on the same edge.
- R11: While `rst_n` is low, every serial output and `pix_take` are low at once (asynchronous). Release passes through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock, seven cycles per link word |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dual | input | 1 | 1: two links, two pixels per word period |
| cfg_deep | input | 1 | 1: eight bits per primary, 0: six bits |
| cfg_jeida | input | 1 | Eight-bit placement: 0 low core/high extras, 1 high core/low extras |
| pix_rgb | input | 24 | Pixel, red [23:16], green [15:8], blue [7:0] |
| pix_hs | input | 1 | Horizontal sync for this pixel |
| pix_vs | input | 1 | Vertical sync for this pixel |
| pix_de | input | 1 | Data enable for this pixel |
| pix_take | output | 1 | High in the cycle whose closing edge samples the pixel |
| odd_lane | output | 4 | Odd-link serial data lanes 3..0 |
| odd_clk | output | 1 | Odd-link clock lane |
| even_lane | output | 4 | Even-link serial data lanes 3..0 |
| even_clk | output | 1 | Even-link clock lane |

## Verification
`pix_take` is combinational on the phase register. The bench therefore reads it at a falling edge and drives the pixel in that same half cycle. Slot 6 of a word appears at the first falling edge after the loading rise, and slot 0 appears six falling edges later. The bench gathers exactly those seven samples per lane and rebuilds the words. During the same window it counts `pix_take` pulses: one in single mode, two in dual. Reset is checked one nanosecond after `rst_n` falls in the middle of a word, and again while it is held low.

// File: rtl/lvds_tx_pkg.sv
package lvds_tx_pkg;
  localparam int WORD_W     = 7;
  localparam int DATA_LANES = 4;
  localparam int CH_W       = 8;
  localparam int LINKS      = 2;
  localparam logic [WORD_W-1:0] CLK_WORD = 7'b1100011;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
    logic            hs;
    logic            vs;
    logic            de;
  } pix_t;
endpackage

// File: rtl/lvds_phase_gen.sv
module lvds_phase_gen #(
  parameter int W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  output logic [$clog2(W)-1:0] ph_o,
  output logic                 mid_o,
  output logic                 load_o
);
  localparam int PW  = $clog2(W);
  localparam int MID = W / 2;

  logic [PW-1:0] ph_q, ph_n;

  always_comb begin
    ph_n = (ph_q == PW'(W - 1)) ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_n;
  end

  assign ph_o   = ph_q;
  assign mid_o  = (ph_q == PW'(MID));
  assign load_o = (ph_q == PW'(W - 1));

  // R1: phase wraps from the last slot back to zero
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> (ph_q == '0));
endmodule

// File: rtl/lvds_lane_map.sv
module lvds_lane_map
  import lvds_tx_pkg::*;
(
  input  pix_t                                  px,
  input  logic                                  en,
  input  logic                                  deep,
  input  logic                                  jeida,
  output logic [DATA_LANES-1:0][WORD_W-1:0]     lanes
);
  localparam int CORE_W = CH_W - 2;

  logic [CORE_W-1:0] rc, gc, bc;
  logic [1:0]        rx, gx, bx;

  always_comb begin
    if (deep && !jeida) begin
      rc = px.r[CORE_W-1:0];
      gc = px.g[CORE_W-1:0];
      bc = px.b[CORE_W-1:0];
    end else begin
      rc = px.r[CH_W-1:2];
      gc = px.g[CH_W-1:2];
      bc = px.b[CH_W-1:2];
    end
    if (jeida) begin
      rx = px.r[1:0];
      gx = px.g[1:0];
      bx = px.b[1:0];
    end else begin
      rx = px.r[CH_W-1:CH_W-2];
      gx = px.g[CH_W-1:CH_W-2];
      bx = px.b[CH_W-1:CH_W-2];
    end
    lanes[0] = {gc[0], rc};
    lanes[1] = {bc[1:0], gc[CORE_W-1:1]};
    lanes[2] = {px.de, px.vs, px.hs, bc[CORE_W-1:2]};
    lanes[3] = deep ? {rx, gx, bx, 1'b0} : '0;
    if (!en) lanes = '0;
  end
endmodule

// File: rtl/lvds_serializer.sv
module lvds_serializer #(
  parameter int LANES = 5,
  parameter int W     = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      load,
  input  logic [LANES-1:0][W-1:0]   word,
  output logic [LANES-1:0]          sout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [W-1:0] sh_q, sh_n;

    always_comb begin
      sh_n = load ? word[i] : {sh_q[W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '0;
      else        sh_q <= sh_n;
    end

    assign sout[i] = sh_q[W-1];

    // R2: top slot of the loaded word is on the line the cycle after load
    p_first_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (sout[i] == $past(word[i][W-1])));
  end
endmodule

// File: rtl/lvds_tx_packer.sv
module lvds_tx_packer
  import lvds_tx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_dual,
  input  logic                    cfg_deep,
  input  logic                    cfg_jeida,
  input  logic [3*CH_W-1:0]       pix_rgb,
  input  logic                    pix_hs,
  input  logic                    pix_vs,
  input  logic                    pix_de,
  output logic                    pix_take,
  output logic [DATA_LANES-1:0]   odd_lane,
  output logic                    odd_clk,
  output logic [DATA_LANES-1:0]   even_lane,
  output logic                    even_clk
);
  localparam int LANES = DATA_LANES + 1;
  localparam int PW    = $clog2(WORD_W);

  // reset: asserted asynchronously, released through two flops
  logic rs1_q, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q <= 1'b0;
      rst_i <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rst_i <= rs1_q;
    end
  end

  logic [PW-1:0] ph;
  logic          mid, load;

  lvds_phase_gen #(.W(WORD_W)) u_phase (
    .clk   (clk),
    .rst_n (rst_i),
    .ph_o  (ph),
    .mid_o (mid),
    .load_o(load)
  );

  pix_t px_in;
  always_comb begin
    px_in.r  = pix_rgb[3*CH_W-1:2*CH_W];
    px_in.g  = pix_rgb[2*CH_W-1:CH_W];
    px_in.b  = pix_rgb[CH_W-1:0];
    px_in.hs = pix_hs;
    px_in.vs = pix_vs;
    px_in.de = pix_de;
  end

  logic mid_take;
  assign mid_take = cfg_dual & mid;
  assign pix_take = load | mid_take;

  // odd/even steering: sel marks that the first pixel of the pair is held
  logic sel_q, sel_n;
  pix_t hold_q, hold_n;
  logic primed_q, primed_n;

  always_comb begin
    sel_n    = sel_q;
    hold_n   = hold_q;
    primed_n = primed_q | load;
    if (load)          sel_n = 1'b0;
    else if (mid_take) sel_n = 1'b1;
    if (mid_take && !sel_q) hold_n = px_in;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sel_q    <= 1'b0;
      hold_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      sel_q    <= sel_n;
      hold_q   <= hold_n;
      primed_q <= primed_n;
    end
  end

  pix_t [LINKS-1:0]                                link_px;
  logic [LINKS-1:0]                                link_en;
  logic [LINKS-1:0][DATA_LANES-1:0][WORD_W-1:0]    map_lanes;
  logic [LINKS-1:0][LANES-1:0][WORD_W-1:0]         words;
  logic [LINKS-1:0][LANES-1:0]                     ser_out;

  assign link_px[0] = cfg_dual ? hold_q : px_in;
  assign link_px[1] = px_in;
  assign link_en[0] = 1'b1;
  assign link_en[1] = cfg_dual;

  for (genvar k = 0; k < LINKS; k++) begin : g_link
    lvds_lane_map u_map (
      .px   (link_px[k]),
      .en   (link_en[k]),
      .deep (cfg_deep),
      .jeida(cfg_jeida),
      .lanes(map_lanes[k])
    );

    assign words[k] = {(link_en[k] ? CLK_WORD : {WORD_W{1'b0}}), map_lanes[k]};

    lvds_serializer #(.LANES(LANES), .W(WORD_W)) u_ser (
      .clk  (clk),
      .rst_n(rst_i),
      .load (load),
      .word (words[k]),
      .sout (ser_out[k])
    );
  end

  assign odd_lane  = ser_out[0][DATA_LANES-1:0];
  assign odd_clk   = ser_out[0][DATA_LANES];
  assign even_lane = ser_out[1][DATA_LANES-1:0];
  assign even_clk  = ser_out[1][DATA_LANES];

  // R1: take strobe is never two cycles wide
  p_take_gap_r1: assert property (@(posedge clk) disable iff (!rst_i)
    pix_take |=> !pix_take);

  // R10: a dual word load always finds the first pixel parked
  p_dual_pair_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (load && cfg_dual && $past(cfg_dual, 3)) |-> sel_q);

  // R9: single mode leaves the even link silent
  p_even_idle_r9: assert property (@(posedge clk) disable iff (!rst_i)
    (load && !cfg_dual) |=> (even_lane == '0 && !even_clk));

  // R4: lane 2 leads with the data-enable of the sampled pixel
  p_ctrl_de_r4: assert property (@(posedge clk) disable iff (!rst_i)
    (load && !cfg_dual) |=> (odd_lane[2] == $past(pix_de)));

  // R7: six-bit words leave lane 3 low
  p_lane3_low_r7: assert property (@(posedge clk) disable iff (!rst_i)
    (load && !cfg_deep) |=> (!odd_lane[3] && !even_lane[3]));

  // R8: clock lane follows the fixed pattern by phase once running
  p_clk_pattern_r8: assert property (@(posedge clk) disable iff (!rst_i)
    primed_q |-> (odd_clk == CLK_WORD[PW'(WORD_W - 1) - ph]));
endmodule

// File: tb/lvds_tx_packer_bench.sv
module lvds_tx_packer_bench;
  import lvds_tx_pkg::*;

  typedef logic [3:0][6:0] lanes_t;

  logic clk;
  logic rst_n, cfg_dual, cfg_deep, cfg_jeida;
  logic [23:0] pix_rgb;
  logic pix_hs, pix_vs, pix_de;
  logic pix_take;
  logic [3:0] odd_lane, even_lane;
  logic odd_clk, even_clk;

  int n_chk = 0;
  int n_bad = 0;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  lvds_tx_packer u_lvds_tx_packer (
    .clk(clk), .rst_n(rst_n), .cfg_dual(cfg_dual), .cfg_deep(cfg_deep),
    .cfg_jeida(cfg_jeida), .pix_rgb(pix_rgb), .pix_hs(pix_hs), .pix_vs(pix_vs),
    .pix_de(pix_de), .pix_take(pix_take), .odd_lane(odd_lane), .odd_clk(odd_clk),
    .even_lane(even_lane), .even_clk(even_clk)
  );

  // {dual, deep, jeida, first pixel {rgb,hs,vs,de}, second pixel}
  localparam int NV = 8;
  localparam logic [56:0] VEC [NV] = '{
    {3'b010, 24'hC35A96, 3'b101, 24'h000000, 3'b000},
    {3'b011, 24'hC35A96, 3'b101, 24'h000000, 3'b000},
    {3'b000, 24'hFF00A5, 3'b010, 24'h000000, 3'b000},
    {3'b001, 24'hFF00A5, 3'b010, 24'h000000, 3'b000},
    {3'b110, 24'h123456, 3'b001, 24'hFEDCBA, 3'b110},
    {3'b111, 24'h817EC0, 3'b111, 24'h03F00F, 3'b000},
    {3'b100, 24'h55AA33, 3'b100, 24'hCC9966, 3'b011},
    {3'b010, 24'hFFFFFF, 3'b111, 24'h000000, 3'b000}
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, expv);
    end
  endtask

  // expected lane words, written from R3..R7
  function automatic lanes_t exp_map(input pix_t p, input logic deep, input logic jei);
    logic [5:0] rc, gc, bc;
    logic [1:0] rx, gx, bx;
    lanes_t w;
    if (deep && !jei) begin rc = p.r[5:0]; gc = p.g[5:0]; bc = p.b[5:0]; end
    else              begin rc = p.r[7:2]; gc = p.g[7:2]; bc = p.b[7:2]; end
    if (jei) begin rx = p.r[1:0]; gx = p.g[1:0]; bx = p.b[1:0]; end
    else     begin rx = p.r[7:6]; gx = p.g[7:6]; bx = p.b[7:6]; end
    w[0] = {gc[0], rc};
    w[1] = {bc[1:0], gc[5:1]};
    w[2] = {p.de, p.vs, p.hs, bc[5:2]};
    w[3] = deep ? {rx, gx, bx, 1'b0} : 7'd0;
    return w;
  endfunction

  task automatic set_px(input pix_t p);
    pix_rgb = {p.r, p.g, p.b};
    pix_hs  = p.hs;
    pix_vs  = p.vs;
    pix_de  = p.de;
  endtask

  task automatic wait_take();
    do @(negedge clk); while (!pix_take);
  endtask

  task automatic run_vec(input logic [56:0] v);
    logic dual, deep, jei;
    pix_t pa, pb;
    lanes_t co, ce, eo, ee;
    logic [6:0] cko, cke;
    int takes;
    string tag;
    dual = v[56]; deep = v[55]; jei = v[54];
    pa = v[53:27]; pb = v[26:0];
    @(negedge clk);
    cfg_dual = dual; cfg_deep = deep; cfg_jeida = jei;
    wait_take();
    set_px(pa);
    if (dual) begin
      wait_take();
      set_px(pb);
    end
    co = '0; ce = '0; cko = '0; cke = '0; takes = 0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      if (pix_take) takes++;
      for (int l = 0; l < 4; l++) begin
        co[l] = {co[l][5:0], odd_lane[l]};
        ce[l] = {ce[l][5:0], even_lane[l]};
      end
      cko = {cko[5:0], odd_clk};
      cke = {cke[5:0], even_clk};
    end
    eo = exp_map(pa, deep, jei);
    ee = dual ? exp_map(pb, deep, jei) : '0;
    if (dual)           tag = "R10";
    else if (!deep)     tag = "R7";
    else if (jei)       tag = "R6";
    else                tag = "R5";
    for (int l = 0; l < 4; l++) begin
      chk(co[l] == eo[l], $sformatf("%s R2 R3 R4 odd lane%0d", tag, l), 32'(co[l]), 32'(eo[l]));
      chk(ce[l] == ee[l], $sformatf("%s R9 even lane%0d", tag, l), 32'(ce[l]), 32'(ee[l]));
    end
    chk(cko == CLK_WORD, "R8 odd clock lane", 32'(cko), 32'(CLK_WORD));
    chk(cke == (dual ? CLK_WORD : 7'd0), "R8 R9 even clock lane", 32'(cke),
        32'(dual ? CLK_WORD : 7'd0));
    chk(takes == (dual ? 2 : 1), "R1 take pulses per word", 32'(takes), dual ? 32'd2 : 32'd1);
  endtask

  task automatic check_idle(input string what);
    chk(odd_lane == 4'd0 && even_lane == 4'd0 && !odd_clk && !even_clk && !pix_take,
        what, {22'd0, pix_take, odd_clk, even_clk, odd_lane, even_lane, 1'b0}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; cfg_dual = 1'b0; cfg_deep = 1'b0; cfg_jeida = 1'b0;
    pix_rgb = '0; pix_hs = 1'b0; pix_vs = 1'b0; pix_de = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_idle("R11 outputs low in reset");
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R11: reset in the middle of a word clears the lines at once
    @(negedge clk);
    cfg_dual = 1'b0; cfg_deep = 1'b1; cfg_jeida = 1'b0;
    wait_take();
    set_px({24'hFFFFFF, 3'b111});
    @(negedge clk);
    @(negedge clk);
    chk(odd_clk == 1'b1, "R8 clock lane high in slot 5", 32'(odd_clk), 32'd1);
    rst_n = 1'b0;
    #1;
    check_idle("R11 async clear mid word");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_idle("R11 held in reset");
    end
    rst_n = 1'b1;
    run_vec(VEC[4]);
    run_vec(VEC[0]);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule